// File: doc/BRIEF.md
# Interleaving Host-to-Device Address Decoder Bank

This block holds a small bank of programmable address decoders that turn a host physical address into a routing decision and a device-local address. Each decoder owns a window given by a base and a byte size. Inside that window, host space is cut into granules, and the granules are dealt round-robin across a set of downstream ports. The device behind any one port sees its granules packed into one dense device-local range.

A narrow command interface programs the decoders and answers each command one cycle later with an accept or reject flag. The same interface commits, disables and locks decoders. Several ordering rules are enforced in hardware:
- Decoders commit strictly in ascending index order.
- Only the highest committed decoder may be disabled.
- Nonzero sizes are given out from low index upward and taken back from the top down.
- A locked decoder stays frozen until a bus-reset pulse clears the whole bank.

Status outputs show, for every decoder, whether it is committed and locked. They also show the number of committed decoders, whether the device is active, and where each decoder's device range falls relative to a volatile/persistent partition boundary.

Top module: `hdb_decode_bank`

## Requirements
- R1: A request hits only when some committed decoder has base <= addr and addr - base < size. Otherwise the response carries the miss flag, with rsp_port = 0 and rsp_dpa = 0.
- R2: When several committed windows contain the address, the decoder with the lowest index answers.
- R3: Ways code w (0..3) means 2^w ways, and granularity code c (0..6) means 2^(8+c) bytes. The interleave position is bits [g+w-1:g] of (addr - base), where g = 8+c. rsp_port is target entry [position] of that decoder. A target write carries the position in data[2:0] and the port in data[6:3]. A ways code above 3 or a granularity code above 6 is rejected.
- R4: With off = addr - base, rsp_dpa = dbase + ((off >> (g+w)) << g) + (off mod 2^g). Here dbase is the sum of size >> w over all lower-indexed decoders.
- R5: Every request is answered exactly one clock after it is presented, and only then.
- R6: A commit of decoder i is accepted only when exactly i decoders are committed, decoder i is not committed, and its size is nonzero.
- R7: A disable is accepted only for the highest committed decoder, and only when that decoder is unlocked.
- R8: Base, size, ways, granularity and target writes to a committed or locked decoder are rejected and leave decoding unchanged. Every command gets cfg_done one cycle later.
- R9: A lock is accepted only on a committed decoder. A locked decoder cannot be disabled. A bus_rst pulse clears every decoder: config, commit and lock.
- R10: A nonzero size write to decoder i is accepted only if i = 0 or decoder i-1 has a nonzero size. A zero size write is accepted only if i is the top decoder or decoder i+1 has size zero.
- R11: Each decoder's dec_mode field (bits 2i+1:2i) reports its device range [dbase, dbase + size>>w) relative to part_bound:
  - 0 when the decoder is not committed;
  - 1 when the range ends at or below part_bound;
  - 2 when the range starts at or above part_bound;
  - 3 when the range straddles part_bound.
- R12: commit_count equals the number of committed decoders, and dev_active is high exactly when that count is nonzero.
- R13: After rst_n, nothing is committed or locked, all modes are 0, and rsp_valid and cfg_done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rst | input | 1 | Synchronous clear of every decoder, including locked ones |
| cfg_valid | input | 1 | Command strobe |
| cfg_idx | input | IW | Decoder index addressed by the command |
| cfg_op | input | 3 | 0 base, 1 size, 2 ways code, 3 granularity code, 4 target, 5 commit, 6 disable, 7 lock |
| cfg_data | input | 32 | Command operand |
| cfg_done | output | 1 | Command answered (one cycle after cfg_valid) |
| cfg_ok | output | 1 | Command accepted |
| part_bound | input | 32 | Device-local volatile/persistent boundary |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | 32 | Host physical address |
| rsp_valid | output | 1 | Decode response valid |
| rsp_hit | output | 1 | Address claimed |
| rsp_miss | output | 1 | Address unclaimed |
| rsp_dec | output | IW | Index of the claiming decoder |
| rsp_port | output | 4 | Selected downstream port |
| rsp_dpa | output | 32 | Device-local address |
| dec_committed | output | NUM_DEC | Per-decoder committed flag |
| dec_locked | output | NUM_DEC | Per-decoder locked flag |
| commit_count | output | CW | Number of committed decoders |
| dev_active | output | 1 | Any decoder committed |
| dec_mode | output | 2*NUM_DEC | Per-decoder partition mode |

## Verification
A corrupted configuration register shows up on the very next decode response. A wrong base or size moves the hit/miss edge at the window boundaries. A wrong ways or granularity field changes rsp_port and rsp_dpa on the first address outside granule 0. A slip in the commit counter is exposed by the following commit or disable, which is then accepted or rejected against the ordering rules, and by commit_count and dec_mode one cycle after the command. A lock that fails to hold shows on the next disable attempt. A bus_rst that fails to clear shows on the next decode, which then hits instead of missing.

// File: rtl/hdb_pkg.sv
package hdb_pkg;
    localparam int AW            = 32;
    localparam int PW            = 4;
    localparam int MAXW          = 8;
    localparam int POSW          = $clog2(MAXW);
    localparam int WAYW          = 2;
    localparam int GRANW         = 3;
    localparam int GRAN_MIN      = 8;
    localparam int MAX_WAYS_CODE = 3;
    localparam int MAX_GRAN_CODE = 6;

    typedef enum logic [2:0] {
        OP_BASE    = 3'd0,
        OP_SIZE    = 3'd1,
        OP_WAYS    = 3'd2,
        OP_GRAN    = 3'd3,
        OP_TGT     = 3'd4,
        OP_COMMIT  = 3'd5,
        OP_DISABLE = 3'd6,
        OP_LOCK    = 3'd7
    } cfg_op_e;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_RAM   = 2'd1,
        MODE_PMEM  = 2'd2,
        MODE_MIXED = 2'd3
    } dec_mode_e;

    typedef struct packed {
        logic [AW-1:0]      base;
        logic [AW-1:0]      size;
        logic [WAYW-1:0]    ways;
        logic [GRANW-1:0]   gran;
        logic [MAXW*PW-1:0] tgt;
        logic               commit;
        logic               lock;
    } dec_cfg_t;
endpackage

// File: rtl/hdb_cfg.sv
module hdb_cfg
    import hdb_pkg::*;
#(
    parameter int NUM_DEC = 4,
    parameter int IW      = 2,
    parameter int CW      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_rst,
    input  logic                         cfg_valid,
    input  logic [IW-1:0]                cfg_idx,
    input  logic [2:0]                   cfg_op,
    input  logic [AW-1:0]                cfg_data,
    output logic                         cfg_done,
    output logic                         cfg_ok,
    output dec_cfg_t [NUM_DEC-1:0]       dec_cfg,
    output logic [NUM_DEC-1:0][AW-1:0]   dec_dbase,
    output logic [CW-1:0]                commit_cnt
);
    typedef struct packed {
        dec_cfg_t [NUM_DEC-1:0] dec;
        logic [CW-1:0]          cnt;
        logic                   done;
        logic                   ok;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    dec_cfg_t   cur;
    logic       in_range, frozen, prev_sized, next_free;
    logic [AW-1:0] acc;

    always_comb begin
        st_d       = st_q;
        st_d.done  = cfg_valid;
        st_d.ok    = 1'b0;
        in_range   = (int'(cfg_idx) < NUM_DEC);
        cur        = st_q.dec[cfg_idx];
        frozen     = cur.commit | cur.lock;
        prev_sized = (cfg_idx == '0) || (st_q.dec[cfg_idx - IW'(1)].size != '0);
        next_free  = (int'(cfg_idx) == NUM_DEC - 1) ||
                     (st_q.dec[cfg_idx + IW'(1)].size == '0);

        if (cfg_valid && in_range) begin
            case (cfg_op_e'(cfg_op))
                OP_BASE: if (!frozen) begin
                    st_d.dec[cfg_idx].base = cfg_data;
                    st_d.ok = 1'b1;
                end
                OP_SIZE: if (!frozen && (((cfg_data != '0) && prev_sized) ||
                                         ((cfg_data == '0) && next_free))) begin
                    st_d.dec[cfg_idx].size = cfg_data;
                    st_d.ok = 1'b1;
                end
                OP_WAYS: if (!frozen && (cfg_data <= AW'(MAX_WAYS_CODE))) begin
                    st_d.dec[cfg_idx].ways = cfg_data[WAYW-1:0];
                    st_d.ok = 1'b1;
                end
                OP_GRAN: if (!frozen && (cfg_data <= AW'(MAX_GRAN_CODE))) begin
                    st_d.dec[cfg_idx].gran = cfg_data[GRANW-1:0];
                    st_d.ok = 1'b1;
                end
                OP_TGT: if (!frozen) begin
                    st_d.dec[cfg_idx].tgt[int'(cfg_data[POSW-1:0])*PW +: PW] =
                        cfg_data[POSW +: PW];
                    st_d.ok = 1'b1;
                end
                OP_COMMIT: if (!cur.commit && (cur.size != '0) &&
                               (st_q.cnt == CW'(cfg_idx))) begin
                    st_d.dec[cfg_idx].commit = 1'b1;
                    st_d.cnt = st_q.cnt + CW'(1);
                    st_d.ok  = 1'b1;
                end
                OP_DISABLE: if (cur.commit && !cur.lock &&
                                (st_q.cnt == CW'(cfg_idx) + CW'(1))) begin
                    st_d.dec[cfg_idx].commit = 1'b0;
                    st_d.cnt = st_q.cnt - CW'(1);
                    st_d.ok  = 1'b1;
                end
                OP_LOCK: if (cur.commit) begin
                    st_d.dec[cfg_idx].lock = 1'b1;
                    st_d.ok = 1'b1;
                end
                default: ;
            endcase
        end

        if (bus_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Device ranges are packed back to back in decoder order.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NUM_DEC; i++) begin
            dec_dbase[i] = acc;
            acc = acc + (st_q.dec[i].size >> st_q.dec[i].ways);
        end
    end

    assign dec_cfg    = st_q.dec;
    assign commit_cnt = st_q.cnt;
    assign cfg_done   = st_q.done;
    assign cfg_ok     = st_q.ok;
endmodule

// File: rtl/hdb_xlate.sv
module hdb_xlate
    import hdb_pkg::*;
(
    input  dec_cfg_t       cfg,
    input  logic [AW-1:0]  dbase,
    input  logic [AW-1:0]  part_bound,
    input  logic [AW-1:0]  addr,
    output logic           hit,
    output logic [PW-1:0]  port,
    output logic [AW-1:0]  dpa,
    output logic [1:0]     mode
);
    logic [AW-1:0]   off, low, high;
    logic [5:0]      gsh;
    logic [POSW-1:0] pos, pos_mask;
    logic [AW:0]     span_end;

    always_comb begin
        off      = addr - cfg.base;
        gsh      = 6'(GRAN_MIN) + 6'(cfg.gran);
        hit      = cfg.commit && (addr >= cfg.base) && (off < cfg.size);
        pos_mask = (POSW'(1) << cfg.ways) - POSW'(1);
        pos      = POSW'(off >> gsh) & pos_mask;
        low      = off & ((AW'(1) << gsh) - AW'(1));
        high     = off >> (gsh + 6'(cfg.ways));
        dpa      = dbase + ((high << gsh) | low);
        port     = cfg.tgt[int'(pos)*PW +: PW];

        span_end = {1'b0, dbase} + {1'b0, (cfg.size >> cfg.ways)};
        if (!cfg.commit)                      mode = MODE_NONE;
        else if (span_end <= {1'b0, part_bound}) mode = MODE_RAM;
        else if (dbase >= part_bound)         mode = MODE_PMEM;
        else                                  mode = MODE_MIXED;
    end
endmodule

// File: rtl/hdb_pick.sv
module hdb_pick
    import hdb_pkg::*;
#(
    parameter int NUM_DEC = 4,
    parameter int IW      = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [NUM_DEC-1:0]         hit,
    input  logic [NUM_DEC-1:0][PW-1:0] port,
    input  logic [NUM_DEC-1:0][AW-1:0] dpa,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic                       rsp_miss,
    output logic [IW-1:0]              rsp_dec,
    output logic [PW-1:0]              rsp_port,
    output logic [AW-1:0]              rsp_dpa
);
    typedef struct packed {
        logic          valid;
        logic          hit;
        logic [IW-1:0] dec;
        logic [PW-1:0] port;
        logic [AW-1:0] dpa;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    always_comb begin
        st_d       = '0;
        st_d.valid = req_valid;
        if (req_valid) begin
            for (int i = NUM_DEC - 1; i >= 0; i--) begin
                if (hit[i]) begin
                    st_d.hit  = 1'b1;
                    st_d.dec  = IW'(i);
                    st_d.port = port[i];
                    st_d.dpa  = dpa[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_hit   = st_q.hit;
    assign rsp_miss  = st_q.valid & ~st_q.hit;
    assign rsp_dec   = st_q.dec;
    assign rsp_port  = st_q.port;
    assign rsp_dpa   = st_q.dpa;
endmodule

// File: rtl/hdb_decode_bank.sv
module hdb_decode_bank
    import hdb_pkg::*;
#(
    parameter int NUM_DEC = 4,
    localparam int IW = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1,
    localparam int CW = $clog2(NUM_DEC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_rst,
    input  logic                 cfg_valid,
    input  logic [IW-1:0]        cfg_idx,
    input  logic [2:0]           cfg_op,
    input  logic [AW-1:0]        cfg_data,
    output logic                 cfg_done,
    output logic                 cfg_ok,
    input  logic [AW-1:0]        part_bound,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [IW-1:0]        rsp_dec,
    output logic [PW-1:0]        rsp_port,
    output logic [AW-1:0]        rsp_dpa,
    output logic [NUM_DEC-1:0]   dec_committed,
    output logic [NUM_DEC-1:0]   dec_locked,
    output logic [CW-1:0]        commit_count,
    output logic                 dev_active,
    output logic [2*NUM_DEC-1:0] dec_mode
);
    dec_cfg_t [NUM_DEC-1:0]       dec_cfg;
    logic [NUM_DEC-1:0][AW-1:0]   dec_dbase;
    logic [NUM_DEC-1:0]           win_hit;
    logic [NUM_DEC-1:0][PW-1:0]   win_port;
    logic [NUM_DEC-1:0][AW-1:0]   win_dpa;

    hdb_cfg #(.NUM_DEC(NUM_DEC), .IW(IW), .CW(CW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst    (bus_rst),
        .cfg_valid  (cfg_valid),
        .cfg_idx    (cfg_idx),
        .cfg_op     (cfg_op),
        .cfg_data   (cfg_data),
        .cfg_done   (cfg_done),
        .cfg_ok     (cfg_ok),
        .dec_cfg    (dec_cfg),
        .dec_dbase  (dec_dbase),
        .commit_cnt (commit_count)
    );

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
        hdb_xlate u_xlate (
            .cfg        (dec_cfg[i]),
            .dbase      (dec_dbase[i]),
            .part_bound (part_bound),
            .addr       (req_addr),
            .hit        (win_hit[i]),
            .port       (win_port[i]),
            .dpa        (win_dpa[i]),
            .mode       (dec_mode[2*i +: 2])
        );
        assign dec_committed[i] = dec_cfg[i].commit;
        assign dec_locked[i]    = dec_cfg[i].lock;
    end

    assign dev_active = |dec_committed;

    hdb_pick #(.NUM_DEC(NUM_DEC), .IW(IW)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hit       (win_hit),
        .port      (win_port),
        .dpa       (win_dpa),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_dec   (rsp_dec),
        .rsp_port  (rsp_port),
        .rsp_dpa   (rsp_dpa)
    );
endmodule

// File: rtl/hdb_checker.sv
module hdb_checker #(
    parameter int NUM_DEC = 4,
    parameter int IW      = 2,
    parameter int CW      = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_rst,
    input logic                 cfg_valid,
    input logic                 cfg_done,
    input logic                 req_valid,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic                 rsp_miss,
    input logic [NUM_DEC-1:0]   dec_committed,
    input logic [NUM_DEC-1:0]   dec_locked,
    input logic [CW-1:0]        commit_count,
    input logic                 dev_active,
    input logic [2*NUM_DEC-1:0] dec_mode
);
    AST_CNT_MATCHES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_count == CW'($countones(dec_committed))); // R12
    AST_ACTIVE_MATCHES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        dev_active == (commit_count != '0)); // R12
    AST_COMMIT_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_committed + NUM_DEC'(1))); // R6
    AST_LOCK_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_locked & ~dec_committed) == '0); // R9
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rst) |-> (($past(dec_locked) & ~dec_locked) == '0)); // R9
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R5
    AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R5
    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss)); // R1
    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss)); // R1
    AST_CMD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_done); // R8

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_mode
        AST_MODE_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_committed[i] |-> (dec_mode[2*i +: 2] == 2'd0)); // R11
    end
endmodule

bind hdb_decode_bank hdb_checker #(.NUM_DEC(NUM_DEC), .IW(IW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rst       (bus_rst),
    .cfg_valid     (cfg_valid),
    .cfg_done      (cfg_done),
    .req_valid     (req_valid),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_miss      (rsp_miss),
    .dec_committed (dec_committed),
    .dec_locked    (dec_locked),
    .commit_count  (commit_count),
    .dev_active    (dev_active),
    .dec_mode      (dec_mode)
);

// File: tb/hdb_decode_bank_tb.sv
module hdb_decode_bank_tb;
    localparam int N  = 4;
    localparam int IW = 2;
    localparam int CW = 3;
    localparam int NV = 12;

    logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0;
    logic cfg_valid = 1'b0, req_valid = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [2:0]  cfg_op = '0;
    logic [31:0] cfg_data = '0, part_bound = 32'h3000, req_addr = '0;
    logic cfg_done, cfg_ok, rsp_valid, rsp_hit, rsp_miss, dev_active;
    logic [IW-1:0] rsp_dec;
    logic [3:0]  rsp_port;
    logic [31:0] rsp_dpa;
    logic [N-1:0] dec_committed, dec_locked;
    logic [CW-1:0] commit_count;
    logic [2*N-1:0] dec_mode;

    int checks = 0, fails = 0;

    logic [31:0] m_base [N];
    logic [31:0] m_size [N];
    int          m_w [N];
    int          m_g [N];
    logic [3:0]  m_tgt [N][8];
    bit          m_on [N];

    // vector table: address, expected decoder (-1 = miss), port, device address
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h1000_0000, 32'h1000_0100, 32'h1000_3FFF, 32'h1000_4000,
        32'h0FFF_FFFF, 32'h2000_0000, 32'h2000_0C00, 32'h2000_4000,
        32'h2000_7FFF, 32'h2000_8000, 32'h2000_1234, 32'h1000_1A55};
    localparam int V_DEC [NV] = '{0, 0, 0, -1, -1, 1, 1, 1, 1, -1, 1, 0};
    localparam logic [3:0] V_PORT [NV] = '{3, 5, 5, 0, 0, 1, 9, 1, 9, 0, 1, 3};
    localparam logic [31:0] V_DPA [NV] = '{
        32'h0, 32'h0, 32'h1FFF, 32'h0, 32'h0, 32'h2000,
        32'h2000, 32'h3000, 32'h3FFF, 32'h0, 32'h2634, 32'hD55};

    hdb_decode_bank #(.NUM_DEC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .cfg_valid(cfg_valid), .cfg_idx(cfg_idx), .cfg_op(cfg_op), .cfg_data(cfg_data),
        .cfg_done(cfg_done), .cfg_ok(cfg_ok), .part_bound(part_bound),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_dec(rsp_dec), .rsp_port(rsp_port), .rsp_dpa(rsp_dpa),
        .dec_committed(dec_committed), .dec_locked(dec_locked),
        .commit_count(commit_count), .dev_active(dev_active), .dec_mode(dec_mode)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input int idx, input int op, input logic [31:0] data,
                       input bit exp_ok, input string tag);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_idx = IW'(idx); cfg_op = 3'(op); cfg_data = data;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk({tag, " cfg_done"}, 64'(cfg_done), 64'(1));
        chk(tag, 64'(cfg_ok), 64'(exp_ok));
    endtask

    task automatic lookup(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic void ref_dec(input logic [31:0] a, output bit h, output int d,
                                    output logic [3:0] p, output logic [31:0] dp);
        logic [31:0] db, off;
        h = 0; d = 0; p = '0; dp = '0; db = '0;
        for (int i = 0; i < N; i++) begin
            off = a - m_base[i];
            if (!h && m_on[i] && a >= m_base[i] && off < m_size[i]) begin
                int gb, pos;
                gb = 8 + m_g[i];
                pos = int'((off >> gb) % (32'd1 << m_w[i]));
                h = 1; d = i; p = m_tgt[i][pos];
                dp = db + ((off >> (gb + m_w[i])) << gb) + (off % (32'd1 << gb));
            end
            db = db + (m_size[i] >> m_w[i]);
        end
    endfunction

    task automatic setup_dec(input int i, input logic [31:0] b, input logic [31:0] s,
                             input int w, input int g);
        cmd(i, 0, b, 1'b1, "R8 base write");
        cmd(i, 1, s, 1'b1, "R10 size write");
        cmd(i, 2, 32'(w), 1'b1, "R3 ways write");
        cmd(i, 3, 32'(g), 1'b1, "R3 gran write");
        m_base[i] = b; m_size[i] = s; m_w[i] = w; m_g[i] = g;
    endtask

    task automatic set_tgt(input int i, input int pos, input int port);
        cmd(i, 4, 32'((port << 3) | pos), 1'b1, "R3 target write");
        m_tgt[i][pos] = 4'(port);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit h; int d; logic [3:0] p; logic [31:0] dp; logic [31:0] a;
        for (int i = 0; i < N; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_w[i] = 0; m_g[i] = 0; m_on[i] = 0;
            for (int j = 0; j < 8; j++) m_tgt[i][j] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 committed", 64'(dec_committed), 64'(0));
        chk("R13 locked", 64'(dec_locked), 64'(0));
        chk("R13 mode", 64'(dec_mode), 64'(0));
        chk("R13 rsp_valid", 64'(rsp_valid), 64'(0));
        chk("R13 cfg_done", 64'(cfg_done), 64'(0));

        // R10 size ordering
        cmd(0, 1, 32'h4000, 1'b1, "R10 size d0");
        cmd(2, 1, 32'h1000, 1'b0, "R10 size d2 before d1");
        setup_dec(0, 32'h1000_0000, 32'h4000, 1, 0);
        setup_dec(1, 32'h2000_0000, 32'h8000, 2, 2);
        setup_dec(2, 32'h2000_4000, 32'h1000, 0, 0);
        cmd(0, 1, 32'h0, 1'b0, "R10 release d0 while d1 sized");
        // R3 illegal codes
        cmd(0, 2, 32'd4, 1'b0, "R3 ways code 4");
        cmd(0, 3, 32'd7, 1'b0, "R3 gran code 7");
        set_tgt(0, 0, 3); set_tgt(0, 1, 5);
        set_tgt(1, 0, 1); set_tgt(1, 1, 2); set_tgt(1, 2, 7); set_tgt(1, 3, 9);
        set_tgt(2, 0, 14);
        chk("R11 none before commit", 64'(dec_mode), 64'(0));

        // R6 commit order
        cmd(1, 5, 32'h0, 1'b0, "R6 commit d1 first");
        cmd(3, 5, 32'h0, 1'b0, "R6 commit d3 out of order");
        cmd(0, 5, 32'h0, 1'b1, "R6 commit d0");
        cmd(1, 5, 32'h0, 1'b1, "R6 commit d1");
        cmd(2, 5, 32'h0, 1'b1, "R6 commit d2");
        cmd(2, 5, 32'h0, 1'b0, "R6 recommit d2");
        cmd(3, 5, 32'h0, 1'b0, "R6 commit d3 zero size");
        m_on[0] = 1; m_on[1] = 1; m_on[2] = 1;
        chk("R12 count", 64'(commit_count), 64'(3));
        chk("R12 active", 64'(dev_active), 64'(1));
        chk("R11 modes bound 0x3000", 64'(dec_mode), 64'h2D);
        part_bound = 32'h2000;
        #1 chk("R11 modes bound 0x2000", 64'(dec_mode), 64'h29);
        part_bound = 32'h3000;

        // R8 writes to committed decoders rejected
        cmd(0, 0, 32'h5000_0000, 1'b0, "R8 base on committed");
        cmd(1, 4, 32'((4 << 3) | 0), 1'b0, "R8 target on committed");
        cmd(1, 2, 32'd0, 1'b0, "R8 ways on committed");

        // table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            lookup(V_ADDR[v]);
            chk($sformatf("R5 valid vec%0d", v), 64'(rsp_valid), 64'(1));
            chk($sformatf("R1 hit vec%0d", v), 64'(rsp_hit), 64'(V_DEC[v] >= 0));
            chk($sformatf("R1 miss vec%0d", v), 64'(rsp_miss), 64'(V_DEC[v] < 0));
            if (V_DEC[v] >= 0)
                chk($sformatf("R2 dec vec%0d", v), 64'(rsp_dec), 64'(V_DEC[v]));
            chk($sformatf("R3 port vec%0d", v), 64'(rsp_port), 64'(V_PORT[v]));
            chk($sformatf("R4 dpa vec%0d", v), 64'(rsp_dpa), 64'(V_DPA[v]));
            @(negedge clk);
            chk($sformatf("R5 single vec%0d", v), 64'(rsp_valid), 64'(0));
        end

        // random addresses against the bench model
        for (int k = 0; k < 300; k++) begin
            if ($urandom % 2 == 0) a = 32'h1000_0000 + ($urandom % 32'h5000) - 32'h400;
            else                   a = 32'h2000_0000 + ($urandom % 32'h9000) - 32'h400;
            ref_dec(a, h, d, p, dp);
            lookup(a);
            chk($sformatf("R1 rand hit a=%0h", a), 64'(rsp_hit), 64'(h));
            if (h) begin
                chk($sformatf("R2 rand dec a=%0h", a), 64'(rsp_dec), 64'(d));
                chk($sformatf("R3 rand port a=%0h", a), 64'(rsp_port), 64'(p));
                chk($sformatf("R4 rand dpa a=%0h", a), 64'(rsp_dpa), 64'(dp));
            end
        end

        // R7 and R9 locking, disable order, bus reset
        cmd(3, 7, 32'h0, 1'b0, "R9 lock uncommitted d3");
        cmd(2, 7, 32'h0, 1'b1, "R9 lock d2");
        chk("R9 locked bits", 64'(dec_locked), 64'h4);
        cmd(1, 6, 32'h0, 1'b0, "R7 disable d1 not highest");
        cmd(2, 6, 32'h0, 1'b0, "R9 disable locked d2");
        cmd(2, 0, 32'h0, 1'b0, "R8 base on locked d2");
        chk("R9 count after refused disable", 64'(commit_count), 64'(3));
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        for (int i = 0; i < N; i++) m_on[i] = 0;
        chk("R9 bus reset committed", 64'(dec_committed), 64'(0));
        chk("R9 bus reset locked", 64'(dec_locked), 64'(0));
        chk("R12 count after bus reset", 64'(commit_count), 64'(0));
        chk("R12 inactive after bus reset", 64'(dev_active), 64'(0));
        lookup(32'h1000_0000);
        chk("R9 miss after bus reset", 64'(rsp_miss), 64'(1));

        // R6 zero size and R7 disable of top decoder
        cmd(0, 5, 32'h0, 1'b0, "R6 commit d0 zero size");
        cmd(0, 1, 32'h1000, 1'b1, "R10 size d0 again");
        cmd(0, 5, 32'h0, 1'b1, "R6 commit d0 again");
        cmd(0, 6, 32'h0, 1'b1, "R7 disable top d0");
        chk("R7 count after disable", 64'(commit_count), 64'(0));
        cmd(0, 6, 32'h0, 1'b0, "R7 disable idle d0");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule